// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

The filter sits between the receive MAC and the descriptor engine of a network controller. When a frame's header becomes available, the MAC raises a one-cycle start strobe. Alongside it the MAC presents the frame length and the destination address. The filter judges that frame against three settings bytes, the station's own 48-bit address, a 64-bit group-address hash table, the readiness of the receive unit and the command word of the current receive descriptor. One clock later it reports the verdict. For an accepted frame it also gives the descriptor status flags to be written back. Beside the verdict it emits single-cycle pulses that feed the statistics counters and the interrupt logic.

The checks run in a fixed priority. The size rule comes first, then address filtering, then receive-resource availability, then the unsupported-mode check. Only a frame that passes all four is accepted. The short-frame counter pulse does not depend on the outcome, because an undersized frame is still judged on its other merits. When an accepted frame's descriptor carries an end-of-list or suspend flag, the filter signals that the receive unit must move to its suspended state.

Top module: `rx_accept_filter`

## Requirements
- R1: A frame with `frm_len` below 64 raises `ev_short_err` for one cycle when bit 0 of `cfg_rxmode` is 1. The frame is judged on the remaining rules either way.
- R2: A frame with `frm_len` greater than 1518 (maximum frame 1514 plus 4) is dropped with no pulse other than R1 unless bit 3 of `cfg_size` is 1. A length of exactly 1518 is never dropped for size.
- R3: A destination equal to `station_addr` is accepted with status 0x0000.
- R4: A group destination has bit 0 of its first byte set; the first byte is `frm_dst[47:40]`, so the group bit is `frm_dst[40]`. The hash index is the top 6 bits (bits 31..26) of a CRC-32. That CRC uses polynomial 0x04C11DB7 and starts from all ones, with no final inversion. It runs over the six address bytes, first byte first and each byte least significant bit first. Table bit `8*(index>>3) + (index&7)` of `hash_tbl`, i.e. bit `index`, accepts the frame when 1, with status 0x0002.
- R5: The all-ones broadcast destination is accepted with status 0x0002 whatever the hash table holds.
- R6: With bit 0 of `cfg_filter` at 1, a frame that no other address rule accepts is still accepted with status bit 0x0004. For a group frame that misses the hash, the status is 0x0006.
- R7: A frame that no address rule accepts while promiscuous mode is off is dropped. It raises no `ev_rnr`, `ev_resource_err`, `ev_good` or `ev_frame_rx`.
- R8: A frame that passes the size and address rules while `ru_ready` is 0 is rejected and raises both `ev_rnr` and `ev_resource_err`.
- R9: A frame that passes the size, address and resource rules while bit 2 of `cfg_size` (CRC transfer to memory) is 1 is rejected as unsupported, with no counter pulse.
- R10: An accepted frame raises `res_accept`, `ev_good` and `ev_frame_rx`. It also raises `ev_ru_suspend` when bit 15 or bit 14 of `desc_cmd` is 1.
- R11: All results are registered at the edge that samples `frm_valid`, last exactly one cycle, and are all 0 in a cycle that follows no strobe and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle frame start strobe |
| frm_len | input | 16 | Frame length in bytes |
| frm_dst | input | 48 | Destination address, first byte in bits 47:40 |
| cfg_rxmode | input | 8 | Settings byte; bit 0 counts short frames |
| cfg_filter | input | 8 | Settings byte; bit 0 promiscuous |
| cfg_size | input | 8 | Settings byte; bit 3 long frames allowed, bit 2 CRC transfer |
| station_addr | input | 48 | Own individual address |
| hash_tbl | input | 64 | Group-address hash table |
| ru_ready | input | 1 | Receive unit has a free descriptor |
| desc_cmd | input | 16 | Command word of current descriptor |
| res_valid | output | 1 | A verdict is presented this cycle |
| res_accept | output | 1 | Frame accepted |
| res_status | output | 16 | Descriptor status flags, zero unless accepted |
| ev_short_err | output | 1 | Short-frame counter pulse |
| ev_good | output | 1 | Good-frame counter pulse |
| ev_resource_err | output | 1 | Resource-error counter pulse |
| ev_rnr | output | 1 | Receive-unit-not-ready event |
| ev_frame_rx | output | 1 | Frame-received event |
| ev_ru_suspend | output | 1 | Receive unit must enter suspended state |

## Verification
Every result of this block is due exactly one clock after the edge that samples the start strobe, and it lasts only that cycle. The bench raises the strobe on a falling edge and drops it on the next falling edge. It then compares all outputs at that point, half a cycle after the registering edge and before the next one can clear them. The bench also checks the cycle after that, with no strobe, to confirm every pulse has returned to zero. It computes the expected hash index with its own CRC routine, so the hit and miss cases come from the rule in R4 alone.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_W    = 48;
    localparam int STAT_W    = 16;
    localparam int MIN_FRAME = 64;
    localparam int CRC_W     = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;

    localparam logic [STAT_W-1:0] ST_GROUP   = 16'h0002;
    localparam logic [STAT_W-1:0] ST_PROMISC = 16'h0004;

    typedef enum logic [2:0] {
        V_ACCEPT,
        V_SIZE_DROP,
        V_ADDR_DROP,
        V_NO_RESOURCE,
        V_UNSUPPORTED
    } verdict_e;

    typedef struct packed {
        logic              hit;
        logic [STAT_W-1:0] flags;
    } match_t;

    // CRC-32 over the address bytes, first byte first, each byte LSB first.
    function automatic logic [CRC_W-1:0] addr_crc(input logic [ADDR_W-1:0] a);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '1;
        for (int b = 0; b < ADDR_W / 8; b++) begin
            for (int k = 0; k < 8; k++) begin
                fb = c[CRC_W-1] ^ a[ADDR_W - 8 * (b + 1) + k];
                c  = {c[CRC_W-2:0], 1'b0};
                if (fb) c = c ^ CRC_POLY;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_size_check.sv
module rxf_size_check #(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 1514
) (
    input  logic [LEN_W-1:0] len,
    input  logic             long_ok,
    output logic             is_short,
    output logic             size_drop
);
    import rxf_pkg::*;

    localparam int LONG_LIMIT = MAX_FRAME + 4;

    assign is_short  = len < LEN_W'(MIN_FRAME);
    assign size_drop = (len > LEN_W'(LONG_LIMIT)) && !long_ok;
endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match #(
    parameter int HASH_BITS = 6
) (
    input  logic [rxf_pkg::ADDR_W-1:0]  dst,
    input  logic [rxf_pkg::ADDR_W-1:0]  station,
    input  logic [(1<<HASH_BITS)-1:0]   tbl,
    input  logic                        promisc,
    output rxf_pkg::match_t             m
);
    import rxf_pkg::*;

    localparam int NBYTES = ADDR_W / 8;

    logic [NBYTES-1:0]    byte_eq;
    logic [CRC_W-1:0]     crc;
    logic [HASH_BITS-1:0] idx;
    logic                 indiv, grp, bcast, hash_hit;

    for (genvar g = 0; g < NBYTES; g++) begin : g_cmp
        assign byte_eq[g] = dst[8*g +: 8] == station[8*g +: 8];
    end

    assign indiv    = &byte_eq;
    assign grp      = dst[ADDR_W-8];
    assign bcast    = &dst;
    assign crc      = addr_crc(dst);
    assign idx      = crc[CRC_W-1 -: HASH_BITS];
    assign hash_hit = tbl[idx];

    always_comb begin
        m = '0;
        if (indiv) begin
            m.hit = 1'b1;
        end else if (bcast) begin
            m.hit   = 1'b1;
            m.flags = ST_GROUP;
        end else if (grp) begin
            if (hash_hit) begin
                m.hit   = 1'b1;
                m.flags = ST_GROUP;
            end else if (promisc) begin
                m.hit   = 1'b1;
                m.flags = ST_GROUP | ST_PROMISC;
            end
        end else if (promisc) begin
            m.hit   = 1'b1;
            m.flags = ST_PROMISC;
        end
    end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        strobe,
    input  logic                        is_short,
    input  logic                        short_count_en,
    input  logic                        size_drop,
    input  rxf_pkg::match_t             m,
    input  logic                        ru_ready,
    input  logic                        crc_xfer,
    input  logic                        halt_req,
    output logic                        q_valid,
    output logic                        q_accept,
    output logic [rxf_pkg::STAT_W-1:0]  q_status,
    output logic                        q_short,
    output logic                        q_no_res,
    output logic                        q_suspend
);
    import rxf_pkg::*;

    verdict_e v;
    logic     acc;

    always_comb begin
        if (size_drop)      v = V_SIZE_DROP;
        else if (!m.hit)    v = V_ADDR_DROP;
        else if (!ru_ready) v = V_NO_RESOURCE;
        else if (crc_xfer)  v = V_UNSUPPORTED;
        else                v = V_ACCEPT;
    end

    assign acc = strobe && (v == V_ACCEPT);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid   <= 1'b0;
            q_accept  <= 1'b0;
            q_status  <= '0;
            q_short   <= 1'b0;
            q_no_res  <= 1'b0;
            q_suspend <= 1'b0;
        end else begin
            q_valid   <= strobe;
            q_accept  <= acc;
            q_status  <= acc ? m.flags : '0;
            q_short   <= strobe && is_short && short_count_en;
            q_no_res  <= strobe && (v == V_NO_RESOURCE);
            q_suspend <= acc && halt_req;
        end
    end
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter #(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 1514,
    parameter int HASH_BITS = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frm_valid,
    input  logic [LEN_W-1:0]        frm_len,
    input  logic [47:0]             frm_dst,
    input  logic [7:0]              cfg_rxmode,
    input  logic [7:0]              cfg_filter,
    input  logic [7:0]              cfg_size,
    input  logic [47:0]             station_addr,
    input  logic [(1<<HASH_BITS)-1:0] hash_tbl,
    input  logic                    ru_ready,
    input  logic [15:0]             desc_cmd,
    output logic                    res_valid,
    output logic                    res_accept,
    output logic [15:0]             res_status,
    output logic                    ev_short_err,
    output logic                    ev_good,
    output logic                    ev_resource_err,
    output logic                    ev_rnr,
    output logic                    ev_frame_rx,
    output logic                    ev_ru_suspend
);
    import rxf_pkg::*;

    localparam int BIT_SHORT_CNT = 0;
    localparam int BIT_PROMISC   = 0;
    localparam int BIT_LONG_OK   = 3;
    localparam int BIT_CRC_XFER  = 2;
    localparam int BIT_EOL       = 15;
    localparam int BIT_SUSP      = 14;

    logic   is_short, size_drop, no_res;
    match_t m;

    logic unused_bits;
    assign unused_bits = ^{cfg_rxmode[7:1], cfg_filter[7:1], cfg_size[7:4],
                           cfg_size[1:0], desc_cmd[13:0]};

    rxf_size_check #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_size (
        .len       (frm_len),
        .long_ok   (cfg_size[BIT_LONG_OK]),
        .is_short  (is_short),
        .size_drop (size_drop)
    );

    rxf_addr_match #(.HASH_BITS(HASH_BITS)) u_match (
        .dst     (frm_dst),
        .station (station_addr),
        .tbl     (hash_tbl),
        .promisc (cfg_filter[BIT_PROMISC]),
        .m       (m)
    );

    rxf_decide u_decide (
        .clk            (clk),
        .rst            (rst),
        .strobe         (frm_valid),
        .is_short       (is_short),
        .short_count_en (cfg_rxmode[BIT_SHORT_CNT]),
        .size_drop      (size_drop),
        .m              (m),
        .ru_ready       (ru_ready),
        .crc_xfer       (cfg_size[BIT_CRC_XFER]),
        .halt_req       (desc_cmd[BIT_EOL] | desc_cmd[BIT_SUSP]),
        .q_valid        (res_valid),
        .q_accept       (res_accept),
        .q_status       (res_status),
        .q_short        (ev_short_err),
        .q_no_res       (no_res),
        .q_suspend      (ev_ru_suspend)
    );

    assign ev_rnr          = no_res;
    assign ev_resource_err = no_res;
    assign ev_good         = res_accept;
    assign ev_frame_rx     = res_accept;
endmodule

// File: rtl/rx_accept_filter_chk.sv
module rx_accept_filter_chk #(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 1514
) (
    input logic             clk,
    input logic             rst,
    input logic             frm_valid,
    input logic [LEN_W-1:0] frm_len,
    input logic [7:0]       cfg_rxmode,
    input logic [7:0]       cfg_size,
    input logic             ru_ready,
    input logic             res_valid,
    input logic             res_accept,
    input logic [15:0]      res_status,
    input logic             ev_short_err,
    input logic             ev_good,
    input logic             ev_rnr,
    input logic             ev_ru_suspend
);
    localparam int LIMIT = MAX_FRAME + 4;

    p_short_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        frm_valid && frm_len < LEN_W'(64) && cfg_rxmode[0] |=> ev_short_err);

    p_long_drop_r2: assert property (@(posedge clk) disable iff (rst)
        frm_valid && frm_len > LEN_W'(LIMIT) && !cfg_size[3]
        |=> !res_accept && !ev_rnr);

    p_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
        frm_valid && !ru_ready |=> !res_accept && !ev_good);

    p_crc_xfer_r9: assert property (@(posedge clk) disable iff (rst)
        frm_valid && cfg_size[2] |=> !res_accept && !ev_good);

    p_suspend_needs_accept_r10: assert property (@(posedge clk) disable iff (rst)
        ev_ru_suspend |-> res_accept);

    p_status_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !res_accept |-> res_status == 16'h0000);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !res_valid && !ev_short_err && !ev_good && !ev_rnr);
endmodule

bind rx_accept_filter rx_accept_filter_chk #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .frm_valid     (frm_valid),
    .frm_len       (frm_len),
    .cfg_rxmode    (cfg_rxmode),
    .cfg_size      (cfg_size),
    .ru_ready      (ru_ready),
    .res_valid     (res_valid),
    .res_accept    (res_accept),
    .res_status    (res_status),
    .ev_short_err  (ev_short_err),
    .ev_good       (ev_good),
    .ev_rnr        (ev_rnr),
    .ev_ru_suspend (ev_ru_suspend)
);

// File: tb/rx_accept_filter_test.sv
module rx_accept_filter_test;

    localparam logic [47:0] STA   = 48'h001B_210A_0B0C;
    localparam logic [47:0] OTHER = 48'h0211_2233_4455;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MCAST = 48'h0100_5E00_00FB;

    typedef struct packed {
        logic [7:0]  req;
        logic [15:0] len;
        logic [47:0] dst;
        logic [7:0]  c_mode, c_filt, c_size;
        logic        rdy;
        logic [15:0] cmd;
        logic        acc;
        logic [15:0] st;
        logic        sh, rnr, sus;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        //  req  len       dst    mode   filt   size   rdy  cmd        acc  st        sh  rnr sus
        '{8'd3,  16'd100,  STA,   8'h00, 8'h00, 8'h00, 1'b1, 16'h0000, 1'b1, 16'h0000, 1'b0,1'b0,1'b0}, // R3
        '{8'd10, 16'd100,  STA,   8'h00, 8'h00, 8'h00, 1'b1, 16'h8000, 1'b1, 16'h0000, 1'b0,1'b0,1'b1}, // R10
        '{8'd10, 16'd100,  STA,   8'h00, 8'h00, 8'h00, 1'b1, 16'h4000, 1'b1, 16'h0000, 1'b0,1'b0,1'b1}, // R10
        '{8'd7,  16'd100,  OTHER, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b0,1'b0,1'b0}, // R7
        '{8'd6,  16'd100,  OTHER, 8'h00, 8'h01, 8'h00, 1'b1, 16'h0000, 1'b1, 16'h0004, 1'b0,1'b0,1'b0}, // R6
        '{8'd5,  16'd100,  BCAST, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0000, 1'b1, 16'h0002, 1'b0,1'b0,1'b0}, // R5
        '{8'd1,  16'd40,   STA,   8'h01, 8'h00, 8'h00, 1'b1, 16'h0000, 1'b1, 16'h0000, 1'b1,1'b0,1'b0}, // R1
        '{8'd1,  16'd40,   STA,   8'h00, 8'h00, 8'h00, 1'b1, 16'h0000, 1'b1, 16'h0000, 1'b0,1'b0,1'b0}, // R1
        '{8'd2,  16'd1519, STA,   8'h00, 8'h00, 8'h00, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b0,1'b0,1'b0}, // R2
        '{8'd2,  16'd1519, STA,   8'h00, 8'h00, 8'h08, 1'b1, 16'h0000, 1'b1, 16'h0000, 1'b0,1'b0,1'b0}, // R2
        '{8'd2,  16'd1518, STA,   8'h00, 8'h00, 8'h00, 1'b1, 16'h0000, 1'b1, 16'h0000, 1'b0,1'b0,1'b0}, // R2
        '{8'd8,  16'd100,  STA,   8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0,1'b1,1'b0}, // R8
        '{8'd9,  16'd100,  STA,   8'h00, 8'h00, 8'h04, 1'b1, 16'hC000, 1'b0, 16'h0000, 1'b0,1'b0,1'b0}, // R9
        '{8'd7,  16'd100,  OTHER, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0,1'b0,1'b0}, // R7
        '{8'd2,  16'd2000, STA,   8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0,1'b0,1'b0}, // R2
        '{8'd1,  16'd40,   OTHER, 8'h01, 8'h00, 8'h00, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b1,1'b0,1'b0}  // R1
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_valid = 1'b0;
    logic [15:0] frm_len = '0;
    logic [47:0] frm_dst = '0;
    logic [7:0]  cfg_rxmode = '0, cfg_filter = '0, cfg_size = '0;
    logic [47:0] station_addr = STA;
    logic [63:0] hash_tbl = '0;
    logic        ru_ready = 1'b1;
    logic [15:0] desc_cmd = '0;
    logic        res_valid, res_accept, ev_short_err, ev_good, ev_resource_err;
    logic        ev_rnr, ev_frame_rx, ev_ru_suspend;
    logic [15:0] res_status;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rx_accept_filter uut (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_len(frm_len),
        .frm_dst(frm_dst), .cfg_rxmode(cfg_rxmode), .cfg_filter(cfg_filter),
        .cfg_size(cfg_size), .station_addr(station_addr), .hash_tbl(hash_tbl),
        .ru_ready(ru_ready), .desc_cmd(desc_cmd), .res_valid(res_valid),
        .res_accept(res_accept), .res_status(res_status),
        .ev_short_err(ev_short_err), .ev_good(ev_good),
        .ev_resource_err(ev_resource_err), .ev_rnr(ev_rnr),
        .ev_frame_rx(ev_frame_rx), .ev_ru_suspend(ev_ru_suspend)
    );

    function automatic logic [5:0] bench_hash(input logic [47:0] a);
        logic [31:0] r = 32'hFFFF_FFFF;
        logic [7:0]  byt;
        for (int n = 0; n < 6; n++) begin
            byt = a[47 - 8*n -: 8];
            for (int k = 0; k < 8; k++) begin
                if (r[31] != byt[k]) r = (r << 1) ^ 32'h04C1_1DB7;
                else                 r = r << 1;
            end
        end
        return r[31:26];
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] len, input logic [47:0] dst);
        @(negedge clk);
        frm_len   = len;
        frm_dst   = dst;
        frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic expect_all(input string req, input logic acc, input logic [15:0] st,
                              input logic sh, input logic rnr, input logic sus);
        chk(req, "res_valid", 16'(res_valid), 16'd1);
        chk(req, "res_accept", 16'(res_accept), 16'(acc));
        chk(req, "res_status", res_status, st);
        chk(req, "ev_short_err", 16'(ev_short_err), 16'(sh));
        chk(req, "ev_good", 16'(ev_good), 16'(acc));
        chk(req, "ev_frame_rx", 16'(ev_frame_rx), 16'(acc));
        chk(req, "ev_rnr", 16'(ev_rnr), 16'(rnr));
        chk(req, "ev_resource_err", 16'(ev_resource_err), 16'(rnr));
        chk(req, "ev_ru_suspend", 16'(ev_ru_suspend), 16'(sus));
    endtask

    task automatic expect_quiet(input string req);
        chk(req, "quiet outputs",
            16'({res_valid, res_accept, ev_short_err, ev_good, ev_resource_err,
                 ev_rnr, ev_frame_rx, ev_ru_suspend}) | res_status, 16'd0);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [5:0] hidx;
        repeat (3) @(negedge clk);
        expect_quiet("R11 reset");
        rst = 1'b0;
        @(negedge clk);
        expect_quiet("R11 after reset");

        for (int i = 0; i < NV; i++) begin
            cfg_rxmode = VECS[i].c_mode;
            cfg_filter = VECS[i].c_filt;
            cfg_size   = VECS[i].c_size;
            ru_ready   = VECS[i].rdy;
            desc_cmd   = VECS[i].cmd;
            send(VECS[i].len, VECS[i].dst);
            expect_all($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].acc,
                       VECS[i].st, VECS[i].sh, VECS[i].rnr, VECS[i].sus);
        end

        @(negedge clk);
        expect_quiet("R11 idle cycle");

        cfg_rxmode = 8'h00; cfg_size = 8'h00; ru_ready = 1'b1; desc_cmd = 16'h0000;
        hidx = bench_hash(MCAST);

        // R4 hash miss, table empty, no promiscuous
        hash_tbl = '0; cfg_filter = 8'h00;
        send(16'd100, MCAST);
        expect_all("R4 empty table", 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);

        // R6 group miss with promiscuous
        cfg_filter = 8'h01;
        send(16'd100, MCAST);
        expect_all("R6 group promiscuous", 1'b1, 16'h0006, 1'b0, 1'b0, 1'b0);

        // R4 hash hit, only the computed bit set
        cfg_filter = 8'h00;
        hash_tbl = 64'd1 << hidx;
        send(16'd100, MCAST);
        expect_all("R4 hash hit", 1'b1, 16'h0002, 1'b0, 1'b0, 1'b0);

        // R4 every bit except the computed one
        hash_tbl = ~(64'd1 << hidx);
        send(16'd100, MCAST);
        expect_all("R4 other bits", 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);

        // R5 broadcast with empty table and hit suspend bit (R10)
        hash_tbl = '0; desc_cmd = 16'h8000;
        send(16'd60, BCAST);
        expect_all("R5 broadcast", 1'b1, 16'h0002, 1'b0, 1'b0, 1'b1);

        // R8 group hit but not ready
        hash_tbl = 64'd1 << hidx; ru_ready = 1'b0; desc_cmd = 16'h0000;
        send(16'd100, MCAST);
        expect_all("R8 group not ready", 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0);

        // R11 reset in the middle clears outputs
        ru_ready = 1'b1;
        send(16'd100, STA);
        rst = 1'b1;
        @(negedge clk);
        expect_quiet("R11 mid reset");
        rst = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule